// File: doc/BRIEF.md
# Fractional-Increment Real-Time Clock With Timestamping

This block keeps wall-clock time in hardware as a seconds count, a nanoseconds count and a hidden sub-nanosecond accumulator. On every reference clock edge it adds a programmable fixed-point step. Because the step has fraction bits, software can trim the effective frequency of the counter in very fine steps. A second stage adds a programmable nanoseconds offset to the free-running count. This produces the synchronized time that the rest of the chip uses. Software uses the offset to set the time after reset and to apply step corrections when it follows a remote master clock.

The synchronized time is sampled into a capture register when a request arrives from another clock domain. The request is a toggle that passes through a two-stage synchronizer. A periodic tick is derived from the synchronized nanoseconds field, and a sticky interrupt flag records it until software clears the flag. The raw nanoseconds count is also brought out directly as the current-value read port.

Top module: `frac_rtc`

## Requirements
- R1: The raw nanoseconds count stays in 0 .. NS_PER_SEC-1 (default 10^9). When a step would reach NS_PER_SEC or more, NS_PER_SEC is subtracted and the raw seconds count is incremented.
- R2: The raw and synchronized seconds counts saturate at all ones (2^SEC_W-1) and never wrap.
- R3: The step is a 26-bit fixed-point word. Bits [25:20] are whole nanoseconds and bits [19:0] are a fraction of a nanosecond. The fractions add into a 20-bit accumulator, and each carry out of it adds one extra nanosecond on that edge.
- R4: The synchronized time is registered one cycle behind the raw count. It equals raw nanoseconds plus the 30-bit offset. A sum of NS_PER_SEC or more has NS_PER_SEC subtracted, and one second is added to the synchronized seconds, saturating.
- R5: A configuration write (cfg_wr high at an edge) loads the step, the offset and the tick select together at that edge. The new step first advances the raw count at the following edge.
- R6: A configuration write whose offset is NS_PER_SEC or more is ignored as a whole: step, offset and tick select all keep their previous values.
- R7: Every change of ts_req_tgl is a capture request. At the third reference edge after the change, ts_ns/ts_sec load the synchronized time that was visible just before that edge, and ts_valid is high for the following cycle.
- R8: tick is high for one cycle whenever a new synchronized nanoseconds value differs from the previous one in bits [31:S], where S is the tick select. The irq flag is set by each tick and held until an irq_clr edge. When both happen at the same edge, the set wins.
- R9: cur_ns always shows the latest raw nanoseconds count.
- R10: After reset all counts, the capture register, tick and irq are zero. The step is NOMINAL_NS whole nanoseconds, the offset is zero, and the tick select is TICK_SEL_RST. Counting starts on the third edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Load step, offset and tick select at this edge |
| cfg_incr | input | 26 | Fixed-point step: [25:20] ns, [19:0] fraction |
| cfg_ofs_ns | input | 30 | Nanoseconds offset added to form synchronized time |
| cfg_tick_sel | input | 5 | Lowest nanoseconds bit position watched by the tick |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| ts_req_tgl | input | 1 | Capture request toggle from another clock domain |
| cur_ns | output | 32 | Raw nanoseconds count |
| sync_ns | output | 32 | Synchronized nanoseconds |
| sync_sec | output | SEC_W | Synchronized seconds |
| tick | output | 1 | One-cycle periodic boundary pulse |
| irq | output | 1 | Sticky interrupt flag |
| ts_valid | output | 1 | One-cycle capture-done pulse |
| ts_ns | output | 32 | Captured synchronized nanoseconds |
| ts_sec | output | SEC_W | Captured synchronized seconds |

## Verification
The bench runs with a one-microsecond "second" and three-bit seconds, so that wraps and saturation come within a few thousand cycles. A whole-number step shows the plain wrap and the carry into the seconds count. A half-nanosecond fraction separates a correct fractional carry from a truncated step. Offsets near the wrap point show the fold into seconds, and an out-of-range offset shows that the whole write is discarded. Random steps, offsets, tick selects, capture toggles and clears then mix all of this up to seconds saturation, and every output is compared each cycle against a bench model.

// File: rtl/frac_rtc_pkg.sv
`timescale 1ns/1ps
package frac_rtc_pkg;
  localparam int unsigned NS_W = 32;
  typedef logic [NS_W-1:0] ns_t;
endpackage

// File: rtl/frac_rtc_cfg.sv
`timescale 1ns/1ps
module frac_rtc_cfg
  import frac_rtc_pkg::*;
#(
  parameter int unsigned INCR_W     = 26,
  parameter int unsigned OFS_W      = 30,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned NS_PER_SEC = 1000000000,
  parameter logic [INCR_W-1:0] INCR_RST = '0,
  parameter logic [SEL_W-1:0]  SEL_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [INCR_W-1:0] wr_incr,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [SEL_W-1:0]  wr_sel,
  output logic [INCR_W-1:0] incr_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [SEL_W-1:0]  sel_q
);
  localparam ns_t NPS_L = ns_t'(NS_PER_SEC);

  logic accept;
  logic [INCR_W-1:0] incr_d;
  logic [OFS_W-1:0]  ofs_d;
  logic [SEL_W-1:0]  sel_d;

  always_comb begin
    accept = wr_en && (ns_t'(wr_ofs) < NPS_L);
    incr_d = wr_incr;
    ofs_d  = wr_ofs;
    sel_d  = wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incr_q <= INCR_RST;
      ofs_q  <= '0;
      sel_q  <= SEL_RST;
    end else if (accept) begin
      incr_q <= incr_d;
      ofs_q  <= ofs_d;
      sel_q  <= sel_d;
    end
  end

  AST_BAD_OFS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ns_t'(wr_ofs) >= NPS_L) |=> ($stable(incr_q) && $stable(ofs_q) && $stable(sel_q))) // R6
    else $error("rejected write changed configuration");
endmodule

// File: rtl/frac_rtc_counter.sv
`timescale 1ns/1ps
module frac_rtc_counter
  import frac_rtc_pkg::*;
#(
  parameter int unsigned INCR_W     = 26,
  parameter int unsigned FRAC_W     = 20,
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INCR_W-1:0] incr,
  output ns_t               ns_q,
  output logic [SEC_W-1:0]  sec_q
);
  localparam ns_t NPS_L = ns_t'(NS_PER_SEC);
  localparam logic [SEC_W-1:0] SEC_MAX = '1;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   frac_sum;
  ns_t               ns_sum, ns_d;
  logic              wrap;
  logic [SEC_W-1:0]  sec_d;

  always_comb begin
    frac_sum = {1'b0, frac_q} + {1'b0, incr[FRAC_W-1:0]};
    frac_d   = frac_sum[FRAC_W-1:0];
    ns_sum   = ns_q + ns_t'(incr[INCR_W-1:FRAC_W]) + ns_t'(frac_sum[FRAC_W]);
    wrap     = (ns_sum >= NPS_L);
    ns_d     = wrap ? (ns_sum - NPS_L) : ns_sum;
    sec_d    = (wrap && (sec_q != SEC_MAX)) ? (sec_q + SEC_W'(1)) : sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
      ns_q   <= '0;
      sec_q  <= '0;
    end else begin
      frac_q <= frac_d;
      ns_q   <= ns_d;
      sec_q  <= sec_d;
    end
  end

  AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q < NPS_L) // R1
    else $error("raw ns out of range");
  AST_SEC_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q == SEC_MAX) |=> (sec_q == SEC_MAX)) // R2
    else $error("seconds wrapped");
  AST_SEC_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_W'(1))) // R1
    else $error("seconds jumped");
endmodule

// File: rtl/frac_rtc_sync_stage.sv
`timescale 1ns/1ps
module frac_rtc_sync_stage
  import frac_rtc_pkg::*;
#(
  parameter int unsigned OFS_W      = 30,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ns_t              raw_ns,
  input  logic [SEC_W-1:0] raw_sec,
  input  logic [OFS_W-1:0] ofs,
  input  logic [SEL_W-1:0] sel,
  input  logic             irq_clr,
  output ns_t              tm_ns_q,
  output logic [SEC_W-1:0] tm_sec_q,
  output logic             tick_q,
  output logic             irq_q
);
  localparam ns_t NPS_L = ns_t'(NS_PER_SEC);
  localparam logic [SEC_W-1:0] SEC_MAX = '1;

  ns_t              sum, tm_ns_d;
  logic             fold;
  logic [SEC_W-1:0] tm_sec_d;
  logic             tick_d, irq_d;

  always_comb begin
    sum      = raw_ns + ns_t'(ofs);
    fold     = (sum >= NPS_L);
    tm_ns_d  = fold ? (sum - NPS_L) : sum;
    tm_sec_d = (fold && (raw_sec != SEC_MAX)) ? (raw_sec + SEC_W'(1)) : raw_sec;
    tick_d   = ((tm_ns_d >> sel) != (tm_ns_q >> sel));
    irq_d    = (irq_q && !irq_clr) || tick_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_ns_q  <= '0;
      tm_sec_q <= '0;
      tick_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      tm_ns_q  <= tm_ns_d;
      tm_sec_q <= tm_sec_d;
      tick_q   <= tick_d;
      irq_q    <= irq_d;
    end
  end

  AST_SYNC_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tm_ns_q < NPS_L) // R4
    else $error("synchronized ns out of range");
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q) // R8
    else $error("irq dropped without clear");
  AST_TICK_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> irq_q) // R8
    else $error("tick without irq");
endmodule

// File: rtl/frac_rtc_capture.sv
`timescale 1ns/1ps
module frac_rtc_capture
  import frac_rtc_pkg::*;
#(
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  input  ns_t              tm_ns,
  input  logic [SEC_W-1:0] tm_sec,
  output logic             valid_q,
  output ns_t              cap_ns_q,
  output logic [SEC_W-1:0] cap_sec_q
);
  logic meta_q, sync_q, seen_q;
  logic hit;

  always_comb hit = sync_q ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      meta_q  <= req_tgl;
      sync_q  <= meta_q;
      seen_q  <= sync_q;
      valid_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ns_q  <= '0;
      cap_sec_q <= '0;
    end else if (hit) begin
      cap_ns_q  <= tm_ns;
      cap_sec_q <= tm_sec;
    end
  end

  AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(cap_ns_q) && $stable(cap_sec_q))) // R7
    else $error("capture changed without request");
endmodule

// File: rtl/frac_rtc.sv
`timescale 1ns/1ps
module frac_rtc
  import frac_rtc_pkg::*;
#(
  parameter int unsigned INCR_W       = 26,
  parameter int unsigned FRAC_W       = 20,
  parameter int unsigned OFS_W        = 30,
  parameter int unsigned SEL_W        = 5,
  parameter int unsigned SEC_W        = 48,
  parameter int unsigned NS_PER_SEC   = 1000000000,
  parameter int unsigned NOMINAL_NS   = 8,
  parameter int unsigned TICK_SEL_RST = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [INCR_W-1:0] cfg_incr,
  input  logic [OFS_W-1:0]  cfg_ofs_ns,
  input  logic [SEL_W-1:0]  cfg_tick_sel,
  input  logic              irq_clr,
  input  logic              ts_req_tgl,
  output logic [31:0]       cur_ns,
  output logic [31:0]       sync_ns,
  output logic [SEC_W-1:0]  sync_sec,
  output logic              tick,
  output logic              irq,
  output logic              ts_valid,
  output logic [31:0]       ts_ns,
  output logic [SEC_W-1:0]  ts_sec
);
  localparam logic [INCR_W-1:0] INCR_RST = INCR_W'(NOMINAL_NS) << FRAC_W;
  localparam logic [SEL_W-1:0]  SEL_RST  = SEL_W'(TICK_SEL_RST);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [INCR_W-1:0] incr_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [SEL_W-1:0]  sel_q;
  ns_t               raw_ns, tm_ns, cap_ns;
  logic [SEC_W-1:0]  raw_sec, tm_sec, cap_sec;
  logic              tick_q, irq_q, valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  frac_rtc_cfg #(
    .INCR_W(INCR_W), .OFS_W(OFS_W), .SEL_W(SEL_W), .NS_PER_SEC(NS_PER_SEC),
    .INCR_RST(INCR_RST), .SEL_RST(SEL_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr), .wr_incr(cfg_incr),
    .wr_ofs(cfg_ofs_ns), .wr_sel(cfg_tick_sel),
    .incr_q(incr_q), .ofs_q(ofs_q), .sel_q(sel_q)
  );

  frac_rtc_counter #(
    .INCR_W(INCR_W), .FRAC_W(FRAC_W), .SEC_W(SEC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .incr(incr_q), .ns_q(raw_ns), .sec_q(raw_sec)
  );

  frac_rtc_sync_stage #(
    .OFS_W(OFS_W), .SEL_W(SEL_W), .SEC_W(SEC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_sync (
    .clk(clk), .rst_n(rst_int_n), .raw_ns(raw_ns), .raw_sec(raw_sec),
    .ofs(ofs_q), .sel(sel_q), .irq_clr(irq_clr),
    .tm_ns_q(tm_ns), .tm_sec_q(tm_sec), .tick_q(tick_q), .irq_q(irq_q)
  );

  frac_rtc_capture #(.SEC_W(SEC_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .req_tgl(ts_req_tgl),
    .tm_ns(tm_ns), .tm_sec(tm_sec),
    .valid_q(valid_q), .cap_ns_q(cap_ns), .cap_sec_q(cap_sec)
  );

  assign cur_ns   = raw_ns;
  assign sync_ns  = tm_ns;
  assign sync_sec = tm_sec;
  assign tick     = tick_q;
  assign irq      = irq_q;
  assign ts_valid = valid_q;
  assign ts_ns    = cap_ns;
  assign ts_sec   = cap_sec;
endmodule

// File: tb/test_frac_rtc.sv
`timescale 1ns/1ps
module test_frac_rtc;
  localparam int  SEC_W = 3;
  localparam longint NPS   = 1000;
  localparam longint SMAX  = 7;
  localparam longint FMASK = (64'd1 << 20) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, irq_clr, ts_req_tgl;
  logic [25:0] cfg_incr;
  logic [29:0] cfg_ofs_ns;
  logic [4:0]  cfg_tick_sel;
  logic [31:0] cur_ns, sync_ns, ts_ns;
  logic [SEC_W-1:0] sync_sec, ts_sec;
  logic tick, irq, ts_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit req   = 0;

  longint m_frac, m_ns, m_sec, m_incr, m_ofs, m_tmns, m_tmsec, m_tsns, m_tssec;
  int m_sel;
  bit m_tick, m_irq, m_tsv, s1, s2, s3;

  always #4 clk = ~clk;

  frac_rtc #(.SEC_W(SEC_W), .NS_PER_SEC(1000), .TICK_SEL_RST(6)) i_frac_rtc (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_incr(cfg_incr),
    .cfg_ofs_ns(cfg_ofs_ns), .cfg_tick_sel(cfg_tick_sel), .irq_clr(irq_clr),
    .ts_req_tgl(ts_req_tgl), .cur_ns(cur_ns), .sync_ns(sync_ns),
    .sync_sec(sync_sec), .tick(tick), .irq(irq), .ts_valid(ts_valid),
    .ts_ns(ts_ns), .ts_sec(ts_sec)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic compare_all();
    chk("R1/R9 raw ns", longint'(cur_ns), m_ns);
    chk("R4 sync ns", longint'(sync_ns), m_tmns);
    chk("R2/R4 sync sec", longint'(sync_sec), m_tmsec);
    chk("R8 tick", longint'(tick), longint'(m_tick));
    chk("R8 irq", longint'(irq), longint'(m_irq));
    chk("R7 ts_valid", longint'(ts_valid), longint'(m_tsv));
    if (m_tsv) begin
      chk("R7 ts_ns", longint'(ts_ns), m_tsns);
      chk("R7 ts_sec", longint'(ts_sec), m_tssec);
    end
  endtask

  // Drive at the falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(bit wr, longint wi, longint wo, int ws, bit clr, bit tg);
    longint fs, ns_a, sec_a, sn, ss;
    bit hit, tk;
    cfg_wr       = wr;
    cfg_incr     = wi[25:0];
    cfg_ofs_ns   = wo[29:0];
    cfg_tick_sel = ws[4:0];
    irq_clr      = clr;
    if (tg) req = ~req;
    ts_req_tgl   = req;
    @(posedge clk);
    fs    = m_frac + (m_incr & FMASK);
    ns_a  = m_ns + (m_incr >> 20) + (fs >> 20);
    sec_a = m_sec;
    if (ns_a >= NPS) begin ns_a -= NPS; if (sec_a < SMAX) sec_a++; end
    sn = m_ns + m_ofs;
    ss = m_sec;
    if (sn >= NPS) begin sn -= NPS; if (ss < SMAX) ss++; end
    tk  = ((sn >> m_sel) != (m_tmns >> m_sel));
    hit = s2 ^ s3;
    if (hit) begin m_tsns = m_tmns; m_tssec = m_tmsec; end
    m_tsv  = hit;
    m_irq  = (m_irq && !clr) || tk;
    m_tick = tk;
    m_tmns = sn; m_tmsec = ss;
    m_frac = fs & FMASK; m_ns = ns_a; m_sec = sec_a;
    s3 = s2; s2 = s1; s1 = req;
    if (wr && wo < NPS) begin m_incr = wi; m_ofs = wo; m_sel = ws; end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cfg_wr = 0; cfg_incr = '0; cfg_ofs_ns = '0;
    cfg_tick_sel = '0; irq_clr = 0; ts_req_tgl = 0;
    m_frac = 0; m_ns = 0; m_sec = 0; m_incr = 8 << 20; m_ofs = 0;
    m_tmns = 0; m_tmsec = 0; m_tsns = 0; m_tssec = 0; m_sel = 6;
    m_tick = 0; m_irq = 0; m_tsv = 0; s1 = 0; s2 = 0; s3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R10: reset state before counting starts
    chk("R10 cur_ns", longint'(cur_ns), 0);
    chk("R10 sync_ns", longint'(sync_ns), 0);
    chk("R10 sync_sec", longint'(sync_sec), 0);
    chk("R10 irq", longint'(irq), 0);
    chk("R10 ts_ns", longint'(ts_ns), 0);

    // R1: whole 8 ns step wraps after 125 cycles
    idle(130);
    chk("R1 wrapped count", longint'(cur_ns), m_ns);

    // R3 R5: 8.5 ns step, new step used from the following edge
    step(1, (8 << 20) | (1 << 19), 0, 6, 0, 0);
    chk("R5 old step still used", longint'(cur_ns), m_ns);
    idle(40);
    chk("R3 fractional carry", longint'(cur_ns), m_ns);

    // R4: offset near the wrap point folds into seconds
    step(1, 8 << 20, 900, 5, 0, 0);
    idle(30);
    chk("R4 folded sync ns", longint'(sync_ns), m_tmns);

    // R6: out-of-range offset ignores the whole write
    step(1, 30 << 20, 1500, 2, 0, 0);
    idle(3);
    chk("R6 step unchanged", longint'(cur_ns), m_ns);
    chk("R6 offset unchanged", longint'(sync_ns), m_tmns);

    // R7: single capture request
    step(0, 0, 0, 0, 0, 1);
    idle(5);
    chk("R7 captured ns", longint'(ts_ns), m_tsns);

    // R8: clear, then clear coinciding with ticks
    step(0, 0, 0, 0, 1, 0);
    idle(10);
    step(0, 0, 0, 0, 1, 0);
    chk("R8 set wins over clear", longint'(irq), longint'(m_irq));

    // Random mix up to seconds saturation
    for (int i = 0; i < 1500; i++) begin
      bit wr = ($urandom_range(0, 19) == 0);
      longint wi = (longint'($urandom_range(1, 40)) << 20) | longint'($urandom_range(0, 32'hFFFFF));
      longint wo = longint'($urandom_range(0, 1199));
      int ws = int'($urandom_range(2, 8));
      bit clr = ($urandom_range(0, 9) == 0);
      bit tg = ($urandom_range(0, 7) == 0);
      step(wr, wi, wo, ws, clr, tg);
    end
    idle(20);
    chk("R2 seconds saturated", longint'(sync_sec), SMAX);

    done = 1;
    summary();
    $finish;
  end
endmodule